// File: doc/BRIEF.md
# Shared-Bus DMA Channel Arbiter

This block decides which of several DMA channels may use a shared internal data bus in a given clock cycle. Every cycle it looks at the request vector and grants the bus to at most one requesting channel. It registers the result as a one-hot grant vector, an encoded winner index and a valid flag, all of which appear one clock after the requests that produced them.

A run-time mode input selects the scheme. In fixed mode the lowest-numbered requester wins. In rotating mode the search starts at the channel just after the previous winner and wraps around, so that service is shared evenly.

Two memory-to-memory channels sit at the low-priority end of the table. In fixed mode their order depends on the transfer each one is performing. Each channel has a transfer-type flag, where 1 means the transfer touches external memory and 0 means it is internal to internal. Only the flags of these two channels are consulted.

Top module: `dma_bus_arb`

## Requirements
- R1: While reset is asserted and after it is released, before any request, the grant vector and index are zero and valid is low. The block starts in fixed mode with the rotation start at channel 0.
- R2: The grant is registered. Requests sampled at one rising edge produce a grant vector with at most one bit set, and that bit is always a requester from that edge. The index gives that bit's position, and all outputs appear after that edge.
- R3: When no channel requests, the next grant vector is all zeros and valid is low. When any channel requests, valid is high.
- R4: With the mode input at 0 (fixed), the lowest-numbered requesting channel wins.
- R5: In fixed mode the first memory channel (parameter MEM_A, default N_CH-2) ranks above the second (MEM_B, default N_CH-1).
- R6: In fixed mode, suppose MEM_A requests with transfer flag 0 (internal to internal) and MEM_B requests with transfer flag 1 (touches external memory). Then MEM_B ranks above MEM_A. Every other flag pairing keeps MEM_A first.
- R7: With the mode input at 1 (rotating), the search starts at the channel after the previous winner, wraps from N_CH-1 to 0, and grants the first requester found.
- R8: The rotation start moves only in a cycle that issues a grant. Idle cycles leave it in place.
- R9: In the first cycle in which the mode input differs from its previous value, the search starts from channel 0.
- R10: Transfer flags of channels other than MEM_A and MEM_B have no effect. In rotating mode the swap of R6 is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rot_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| req_vec | input | N_CH | Per-channel bus request |
| xfer_ext | input | N_CH | Per-channel transfer type, 1 = touches external memory |
| gnt_oh | output | N_CH | Registered one-hot grant |
| gnt_idx | output | $clog2(N_CH) | Registered winner index |
| gnt_vld | output | 1 | Registered grant valid |

## Verification
The bench builds the arbiter with eight channels, and the two memory channels take the default positions 6 and 7. At this size every pairing of the two transfer flags can be tried with and without lower-numbered requesters. With only eight channels, a rotating walk across the last index back to channel 0 takes a few cycles, so the wrap is tested directly. Mode flips are placed after the pointer has moved, so that a restart at channel 0 is distinguishable from a continued rotation.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic {
        ARB_FIXED  = 1'b0,
        ARB_ROTATE = 1'b1
    } arb_mode_e;

    // Memory channel B overtakes A when A stays internal and B goes external.
    function automatic logic mem_swap(input logic a_ext, input logic b_ext);
        return !a_ext && b_ext;
    endfunction

endpackage

// File: rtl/dma_fixed_pick.sv
module dma_fixed_pick #(
    parameter int N_CH  = 8,
    parameter int MEM_A = N_CH - 2,
    parameter int MEM_B = N_CH - 1,
    localparam int IDX_W = $clog2(N_CH)
) (
    input  logic [N_CH-1:0]  req,
    input  logic             swap,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int p = N_CH - 1; p >= 0; p--) begin
            int ch;
            ch = p;
            if (swap && p == MEM_A) ch = MEM_B;
            else if (swap && p == MEM_B) ch = MEM_A;
            if (req[ch]) begin
                found = 1'b1;
                idx   = IDX_W'(ch);
            end
        end
    end

endmodule

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
    parameter int N_CH = 8,
    localparam int IDX_W = $clog2(N_CH)
) (
    input  logic [N_CH-1:0]  req,
    input  logic [IDX_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N_CH - 1; k >= 0; k--) begin
            int ch;
            ch = (int'(start) + k) % N_CH;
            if (req[ch]) begin
                found = 1'b1;
                idx   = IDX_W'(ch);
            end
        end
    end

endmodule

// File: rtl/dma_bus_arb.sv
module dma_bus_arb
    import dma_arb_pkg::*;
#(
    parameter int N_CH  = 8,
    parameter int MEM_A = N_CH - 2,
    parameter int MEM_B = N_CH - 1,
    localparam int IDX_W = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rot_mode,
    input  logic [N_CH-1:0]  req_vec,
    input  logic [N_CH-1:0]  xfer_ext,
    output logic [N_CH-1:0]  gnt_oh,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_vld
);

    localparam logic [N_CH-1:0] LOW_MASK =
        N_CH'((1 << MEM_A) - 1) & N_CH'((1 << MEM_B) - 1);

    typedef struct packed {
        logic [N_CH-1:0]  oh;
        logic [IDX_W-1:0] idx;
        logic             vld;
        logic [IDX_W-1:0] ptr;
        arb_mode_e        mode;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic             swap;
    logic             mode_chg;
    logic [IDX_W-1:0] rr_start;
    logic             fx_found, rr_found;
    logic [IDX_W-1:0] fx_idx, rr_idx;
    arb_mode_e        mode_in;

    assign mode_in  = arb_mode_e'(rot_mode);
    assign swap     = mem_swap(xfer_ext[MEM_A], xfer_ext[MEM_B]);
    assign mode_chg = (mode_in != st_q.mode);
    assign rr_start = mode_chg ? '0 : st_q.ptr;

    dma_fixed_pick #(.N_CH(N_CH), .MEM_A(MEM_A), .MEM_B(MEM_B)) u_fixed (
        .req   (req_vec),
        .swap  (swap),
        .found (fx_found),
        .idx   (fx_idx)
    );

    dma_rr_pick #(.N_CH(N_CH)) u_rr (
        .req   (req_vec),
        .start (rr_start),
        .found (rr_found),
        .idx   (rr_idx)
    );

    always_comb begin
        logic             win_vld;
        logic [IDX_W-1:0] win;
        st_d      = st_q;
        st_d.mode = mode_in;
        if (mode_in == ARB_ROTATE) begin
            win_vld = rr_found;
            win     = rr_idx;
        end else begin
            win_vld = fx_found;
            win     = fx_idx;
        end
        st_d.vld = win_vld;
        st_d.idx = win_vld ? win : '0;
        st_d.oh  = '0;
        if (win_vld) st_d.oh[win] = 1'b1;
        if (win_vld)
            st_d.ptr = (int'(win) == N_CH - 1) ? '0 : win + 1'b1;
        else if (mode_chg)
            st_d.ptr = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{oh: '0, idx: '0, vld: 1'b0, ptr: '0, mode: ARB_FIXED};
        else        st_q <= st_d;
    end

    assign gnt_oh  = st_q.oh;
    assign gnt_idx = st_q.idx;
    assign gnt_vld = st_q.vld;

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh));

    // R2
    gnt_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_oh & ~$past(req_vec)) == '0);

    // R3
    idle_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vec == '0) |=> !gnt_vld);

    // R3
    busy_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vec != '0) |=> gnt_vld);

    // R6
    mem_swap_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rot_mode && req_vec[MEM_A] && req_vec[MEM_B] && !xfer_ext[MEM_A]
         && xfer_ext[MEM_B] && ((req_vec & LOW_MASK) == '0))
        |=> (int'(gnt_idx) == MEM_B));

endmodule

// File: tb/dma_bus_arb_tb.sv
module dma_bus_arb_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_CH = 8;
    localparam int IDX_W = 3;
    localparam int NV = 11;

    localparam logic [7:0] V_REQ [NV] = '{8'h00, 8'hFF, 8'h28, 8'h80, 8'hC0, 8'hC0,
                                          8'hC0, 8'hC0, 8'hC1, 8'hC0, 8'h40};
    localparam logic [7:0] V_EXT [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80,
                                          8'h40, 8'hC0, 8'h80, 8'h3F, 8'h80};
    localparam int V_IDX [NV] = '{0, 0, 3, 7, 6, 7, 6, 6, 0, 6, 6};
    localparam bit V_VLD [NV] = '{0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1};
    localparam string V_TAG [NV] = '{"R3", "R4", "R4", "R4", "R5", "R6",
                                      "R6", "R6", "R4", "R10", "R6"};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rot_mode = 1'b0;
    logic [N_CH-1:0]  req_vec = '0;
    logic [N_CH-1:0]  xfer_ext = '0;
    logic [N_CH-1:0]  gnt_oh;
    logic [IDX_W-1:0] gnt_idx;
    logic             gnt_vld;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_bus_arb #(.N_CH(N_CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .rot_mode(rot_mode), .req_vec(req_vec),
        .xfer_ext(xfer_ext), .gnt_oh(gnt_oh), .gnt_idx(gnt_idx), .gnt_vld(gnt_vld)
    );

    task automatic check(input string tag, input int e_idx, input bit e_vld);
        logic [N_CH-1:0] e_oh;
        e_oh = e_vld ? N_CH'(1 << e_idx) : '0;
        n_chk++;
        if (gnt_vld !== e_vld || gnt_oh !== e_oh || int'(gnt_idx) != (e_vld ? e_idx : 0)) begin
            n_fail++;
            $display("FAIL %s: vld=%0b oh=%b idx=%0d expected vld=%0b oh=%b idx=%0d",
                     tag, gnt_vld, gnt_oh, gnt_idx, e_vld, e_oh, e_vld ? e_idx : 0);
        end
    endtask

    task automatic step(input logic m, input logic [7:0] r, input logic [7:0] x,
                        input string tag, input int e_idx, input bit e_vld);
        @(negedge clk);
        rot_mode = m;
        req_vec  = r;
        xfer_ext = x;
        @(posedge clk);
        #1;
        check(tag, e_idx, e_vld);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        req_vec = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 0, 0);
        @(negedge clk);
        req_vec = '0;
        rst_n   = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after reset", 0, 0);

        // Fixed-mode table
        for (int i = 0; i < NV; i++)
            step(1'b0, V_REQ[i], V_EXT[i], V_TAG[i], V_IDX[i], V_VLD[i]);

        // Mode flip with all requesting: search from channel 0 (R9)
        step(1'b0, 8'h02, 8'h00, "R4 prep", 1, 1);
        step(1'b1, 8'hFF, 8'h00, "R9 flip to rotate", 0, 1);
        step(1'b1, 8'hFF, 8'h00, "R7 rotate", 1, 1);
        step(1'b1, 8'hFF, 8'h00, "R7 rotate", 2, 1);
        step(1'b1, 8'h00, 8'h00, "R8 idle", 0, 0);
        step(1'b1, 8'h00, 8'h00, "R8 idle", 0, 0);
        step(1'b1, 8'hFF, 8'h00, "R8 hold", 3, 1);
        step(1'b1, 8'h05, 8'h00, "R7 wrap", 0, 1);
        step(1'b1, 8'h05, 8'h00, "R7 next", 2, 1);
        step(1'b1, 8'hC0, 8'h80, "R10 no swap rotate", 6, 1);
        step(1'b1, 8'hC0, 8'h80, "R7 after 6", 7, 1);
        step(1'b1, 8'hC0, 8'h80, "R7 wrap 7", 6, 1);
        step(1'b0, 8'h82, 8'h00, "R4 back fixed", 1, 1);
        step(1'b0, 8'h00, 8'h00, "R3 idle fixed", 0, 0);
        step(1'b1, 8'hFF, 8'h00, "R9 restart at 0", 0, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule